// File: doc/BRIEF.md
# Instruction fetch retry controller

This block sits between a multithreaded instruction fetch stage and an instruction cache. The cache may turn a request away when it has no free miss-handling entry. Each cycle the fetch stage may offer one request, made of a thread id and a line address. The block forwards the request to the cache, which answers accept or refuse in the same cycle. A refused request is parked in one retry slot that all threads share. The cache is then marked blocked, and no thread may start a new fetch. When the cache later pulses its retry line, the parked request goes out again.

The block keeps a status for each thread:

| Code | Status |
|------|--------|
| 0 | running |
| 1 | waiting for retry |
| 2 | waiting for response |
| 3 | squashing |

A squash may arrive while a request is parked. If it hits the thread that owns the parked request, the request is dropped, but the blocked mark stays set. The cache still owes a retry pulse, and only that pulse clears the mark. New fetches are also held off while fetch is switched out, and while an interrupt is pending outside privileged mode.

Top module: `fetch_retry_ctrl`

## Requirements
- R1: After reset every thread status is running (0), `cacheBlocked` is 0, `retryError` is 0, and no cache request is driven.
- R2: No new fetch is forwarded to the cache while `cacheBlocked` is 1, while `switchedOut` is 1, or while `intPending` is 1 and `privMode` is 0. A pending interrupt does not stop a fetch when `privMode` is 1.
- R3: A forwarded fetch drives `cacheReqValid`, `cacheReqTid` and `cacheReqAddr` in the same cycle. If `cacheReqAccept` is 1, the thread's status is waiting for response (2) from the next cycle.
- R4: If a forwarded fetch is refused (`cacheReqAccept` 0), from the next cycle the thread's status is waiting for retry (1) and `cacheBlocked` is 1. The request's tid and address are held in the retry slot.
- R5: On a `cacheRetry` pulse while a request is held, the held tid and address are driven on the cache request in that same cycle. If the cache accepts it, from the next cycle the slot is empty, `cacheBlocked` is 0 and that thread is waiting for response (2).
- R6: If the resent request is refused again, `cacheBlocked` stays 1, the thread stays waiting for retry, and the same request is sent on the next retry pulse.
- R7: A squash of the thread that owns the held request drops the request, sets that thread to squashing (3), and leaves `cacheBlocked` at 1. A later retry pulse drives no cache request and only clears `cacheBlocked`.
- R8: A squash of any other thread sets that thread to squashing (3) and changes neither the held request nor `cacheBlocked`.
- R9: A response (`rspValid`) whose `rspTid` names a thread waiting for response returns that thread to running (0). A response for a thread in any other status is ignored.
- R10: A thread stays squashing for exactly one cycle and then returns to running.
- R11: Only a thread whose status is running may issue a fetch. A fetch from a thread that is being squashed in the same cycle is not forwarded.
- R12: A `cacheRetry` pulse while `cacheBlocked` is 0 raises `retryError` for the following cycle only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetch stage offers a request |
| fetchTid | input | TID_W | Thread of the offered request |
| fetchAddr | input | ADDR_W | Line address of the offered request |
| intPending | input | 1 | Interrupt pending |
| privMode | input | 1 | Core is in privileged mode |
| switchedOut | input | 1 | Fetch is switched out |
| squashValid | input | 1 | Squash strobe |
| squashTid | input | TID_W | Thread being squashed |
| rspValid | input | 1 | Cache returns data |
| rspTid | input | TID_W | Thread of the returned data |
| cacheReqValid | output | 1 | Request to the cache |
| cacheReqTid | output | TID_W | Thread of the cache request |
| cacheReqAddr | output | ADDR_W | Address of the cache request |
| cacheReqAccept | input | 1 | Cache accepts the request in the same cycle |
| cacheRetry | input | 1 | One-cycle retry pulse from the cache |
| cacheBlocked | output | 1 | Cache is marked blocked |
| threadStatus | output | 2*NUM_THREADS | Status of thread t in bits [2t+1:2t] |
| retryError | output | 1 | A retry arrived while not blocked |

## Verification
The fetch path is tried with an accepted first attempt and with a refusal, which tells the direct path to wait-for-response apart from the parking path. The retry path is tried with a resend that is refused and then accepted, which shows that the slot survives a second refusal. Squashes of the owning thread and of another thread are followed by a retry pulse: the first must produce no request and clear the blocked mark, and the second must resend the original address. Gating is tried with each hold-off cause alone, with an interrupt in privileged mode as the case that must still pass, and with fetches from threads that are not running.

// File: rtl/fetch_retry_pkg.sv
`timescale 1ns/1ps
package fetch_retry_pkg;

  typedef enum logic [1:0] {
    THR_RUN      = 2'd0,
    THR_WRETRY   = 2'd1,
    THR_WRSP     = 2'd2,
    THR_SQUASH   = 2'd3
  } thr_state_e;

  typedef struct packed {
    logic sendFromFetch;
    logic sendFromSlot;
    logic loadSlot;
    logic clearSlot;
  } slot_strobe_t;

endpackage

// File: rtl/fetch_retry_datapath.sv
`timescale 1ns/1ps
module fetch_retry_datapath
  import fetch_retry_pkg::*;
#(
  parameter int TID_W  = 2,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  slot_strobe_t      strb,
  input  logic [TID_W-1:0]  fetchTid,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              slotValid,
  output logic [TID_W-1:0]  slotTid,
  output logic              cacheReqValid,
  output logic [TID_W-1:0]  cacheReqTid,
  output logic [ADDR_W-1:0] cacheReqAddr
);

  logic [ADDR_W-1:0] slotAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= 1'b0;
      slotTid   <= '0;
      slotAddr  <= '0;
    end else if (strb.loadSlot) begin
      slotValid <= 1'b1;
      slotTid   <= fetchTid;
      slotAddr  <= fetchAddr;
    end else if (strb.clearSlot) begin
      slotValid <= 1'b0;
    end
  end

  always_comb begin
    cacheReqValid = strb.sendFromFetch | strb.sendFromSlot;
    if (strb.sendFromSlot) begin
      cacheReqTid  = slotTid;
      cacheReqAddr = slotAddr;
    end else begin
      cacheReqTid  = fetchTid;
      cacheReqAddr = fetchAddr;
    end
  end

endmodule

// File: rtl/fetch_retry_control.sv
`timescale 1ns/1ps
module fetch_retry_control
  import fetch_retry_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W       = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fetchValid,
  input  logic [TID_W-1:0]         fetchTid,
  input  logic                     intPending,
  input  logic                     privMode,
  input  logic                     switchedOut,
  input  logic                     squashValid,
  input  logic [TID_W-1:0]         squashTid,
  input  logic                     rspValid,
  input  logic [TID_W-1:0]         rspTid,
  input  logic                     cacheReqAccept,
  input  logic                     cacheRetry,
  input  logic                     slotValid,
  input  logic [TID_W-1:0]         slotTid,
  output slot_strobe_t             strb,
  output logic                     blocked,
  output logic [2*NUM_THREADS-1:0] threadStatus,
  output logic                     retryError
);

  thr_state_e state [NUM_THREADS];

  logic gateOpen, fetchOk, ownerSquash, retryHeld, retryLive, clrBlocked;

  always_comb begin
    gateOpen    = !blocked && !switchedOut && !(intPending && !privMode);
    fetchOk     = fetchValid && gateOpen && (state[fetchTid] == THR_RUN)
                  && !(squashValid && squashTid == fetchTid);
    ownerSquash = squashValid && slotValid && (slotTid == squashTid);
    retryLive   = cacheRetry && blocked;
    retryHeld   = retryLive && slotValid && !ownerSquash;
    clrBlocked  = retryLive && (!retryHeld || cacheReqAccept);

    strb.sendFromFetch = fetchOk;
    strb.sendFromSlot  = retryHeld;
    strb.loadSlot      = fetchOk && !cacheReqAccept;
    strb.clearSlot     = (retryHeld && cacheReqAccept) || ownerSquash;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blocked    <= 1'b0;
      retryError <= 1'b0;
    end else begin
      retryError <= cacheRetry && !blocked;
      if (strb.loadSlot)
        blocked <= 1'b1;
      else if (clrBlocked)
        blocked <= 1'b0;
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    localparam logic [TID_W-1:0] MY_TID = TID_W'(t);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        state[t] <= THR_RUN;
      end else if (squashValid && squashTid == MY_TID) begin
        state[t] <= THR_SQUASH;
      end else if (fetchOk && fetchTid == MY_TID) begin
        state[t] <= cacheReqAccept ? THR_WRSP : THR_WRETRY;
      end else if (retryHeld && cacheReqAccept && slotTid == MY_TID) begin
        state[t] <= THR_WRSP;
      end else if (rspValid && rspTid == MY_TID && state[t] == THR_WRSP) begin
        state[t] <= THR_RUN;
      end else if (state[t] == THR_SQUASH) begin
        state[t] <= THR_RUN;
      end
    end

    assign threadStatus[2*t +: 2] = state[t];
  end

endmodule

// File: rtl/fetch_retry_ctrl.sv
`timescale 1ns/1ps
module fetch_retry_ctrl
  import fetch_retry_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 32,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fetchValid,
  input  logic [TID_W-1:0]         fetchTid,
  input  logic [ADDR_W-1:0]        fetchAddr,
  input  logic                     intPending,
  input  logic                     privMode,
  input  logic                     switchedOut,
  input  logic                     squashValid,
  input  logic [TID_W-1:0]         squashTid,
  input  logic                     rspValid,
  input  logic [TID_W-1:0]         rspTid,
  output logic                     cacheReqValid,
  output logic [TID_W-1:0]         cacheReqTid,
  output logic [ADDR_W-1:0]        cacheReqAddr,
  input  logic                     cacheReqAccept,
  input  logic                     cacheRetry,
  output logic                     cacheBlocked,
  output logic [2*NUM_THREADS-1:0] threadStatus,
  output logic                     retryError
);

  slot_strobe_t     strb;
  logic             slotValid;
  logic [TID_W-1:0] slotTid;

  fetch_retry_control #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchTid(fetchTid),
    .intPending(intPending), .privMode(privMode), .switchedOut(switchedOut),
    .squashValid(squashValid), .squashTid(squashTid),
    .rspValid(rspValid), .rspTid(rspTid),
    .cacheReqAccept(cacheReqAccept), .cacheRetry(cacheRetry),
    .slotValid(slotValid), .slotTid(slotTid),
    .strb(strb), .blocked(cacheBlocked),
    .threadStatus(threadStatus), .retryError(retryError)
  );

  fetch_retry_datapath #(.TID_W(TID_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fetchTid(fetchTid), .fetchAddr(fetchAddr),
    .slotValid(slotValid), .slotTid(slotTid),
    .cacheReqValid(cacheReqValid), .cacheReqTid(cacheReqTid),
    .cacheReqAddr(cacheReqAddr)
  );

endmodule

// File: rtl/fetch_retry_checker.sv
`timescale 1ns/1ps
module fetch_retry_checker (
  input logic clk,
  input logic rstN,
  input logic switchedOut,
  input logic intPending,
  input logic privMode,
  input logic cacheReqValid,
  input logic cacheReqAccept,
  input logic cacheRetry,
  input logic cacheBlocked,
  input logic retryError
);

  // R2: while blocked, only a retry resend reaches the cache
  assert_blocked_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    cacheBlocked && cacheReqValid |-> cacheRetry);

  // R2: switched out or unprivileged interrupt lets no new fetch through
  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (switchedOut || (intPending && !privMode)) && cacheReqValid |-> cacheRetry);

  // R4: a refused new fetch marks the cache blocked
  assert_refuse_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    cacheReqValid && !cacheRetry && !cacheReqAccept |=> cacheBlocked);

  // R5: an accepted resend clears the blocked mark
  assert_retry_unblocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    cacheRetry && cacheReqValid && cacheReqAccept |=> !cacheBlocked);

  // R6: a refused resend keeps the blocked mark
  assert_retry_refused_R6: assert property (@(posedge clk) disable iff (!rstN)
    cacheRetry && cacheReqValid && !cacheReqAccept |=> cacheBlocked);

  // R12: a stray retry raises the error flag
  assert_stray_retry_R12: assert property (@(posedge clk) disable iff (!rstN)
    cacheRetry && !cacheBlocked |=> retryError);

  // R12: the error flag follows only a stray retry
  assert_error_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(cacheRetry && !cacheBlocked) |=> !retryError);

endmodule

bind fetch_retry_ctrl fetch_retry_checker u_chk (
  .clk(clk), .rstN(rstN), .switchedOut(switchedOut),
  .intPending(intPending), .privMode(privMode),
  .cacheReqValid(cacheReqValid), .cacheReqAccept(cacheReqAccept),
  .cacheRetry(cacheRetry), .cacheBlocked(cacheBlocked),
  .retryError(retryError)
);

// File: tb/fetch_retry_ctrl_test.sv
`timescale 1ns/1ps
module fetch_retry_ctrl_test;

  localparam int NT = 4;
  localparam int AW = 32;

  logic clk = 0;
  logic rstN = 0;
  logic fetchValid = 0, intPending = 0, privMode = 0, switchedOut = 0;
  logic [1:0] fetchTid = 0, squashTid = 0, rspTid = 0;
  logic [AW-1:0] fetchAddr = 0;
  logic squashValid = 0, rspValid = 0, cacheReqAccept = 0, cacheRetry = 0;
  logic cacheReqValid, cacheBlocked, retryError;
  logic [1:0] cacheReqTid;
  logic [AW-1:0] cacheReqAddr;
  logic [2*NT-1:0] threadStatus;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fetch_retry_ctrl #(.NUM_THREADS(NT), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN),
    .fetchValid(fetchValid), .fetchTid(fetchTid), .fetchAddr(fetchAddr),
    .intPending(intPending), .privMode(privMode), .switchedOut(switchedOut),
    .squashValid(squashValid), .squashTid(squashTid),
    .rspValid(rspValid), .rspTid(rspTid),
    .cacheReqValid(cacheReqValid), .cacheReqTid(cacheReqTid),
    .cacheReqAddr(cacheReqAddr), .cacheReqAccept(cacheReqAccept),
    .cacheRetry(cacheRetry), .cacheBlocked(cacheBlocked),
    .threadStatus(threadStatus), .retryError(retryError)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] st(int t);
    return threadStatus[2*t +: 2];
  endfunction

  task automatic idle();
    fetchValid = 0; squashValid = 0; rspValid = 0;
    cacheRetry = 0; cacheReqAccept = 0;
    switchedOut = 0; intPending = 0; privMode = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic offer(input logic [1:0] tid, input logic [AW-1:0] a, input logic acc);
    fetchValid = 1; fetchTid = tid; fetchAddr = a; cacheReqAccept = acc;
  endtask

  task automatic respond(input logic [1:0] tid);
    idle(); rspValid = 1; rspTid = tid; tick(); idle();
  endtask

  task automatic t_reset();
    for (int t = 0; t < NT; t++) chk("R1", "status", st(t), 0);
    chk("R1", "blocked", cacheBlocked, 0);
    chk("R1", "error", retryError, 0);
    chk("R1", "reqValid", cacheReqValid, 0);
  endtask

  task automatic t_accept();
    offer(1, 32'h1000, 1); #1;
    chk("R3", "reqValid", cacheReqValid, 1);
    chk("R3", "reqTid", cacheReqTid, 1);
    chk("R3", "reqAddr", cacheReqAddr, 32'h1000);
    tick(); idle();
    chk("R3", "status wait rsp", st(1), 2);
    chk("R3", "blocked", cacheBlocked, 0);
    rspValid = 1; rspTid = 2; tick(); idle();
    chk("R9", "stray rsp ignored", st(2), 0);
    chk("R9", "other thread still waiting", st(1), 2);
    respond(1);
    chk("R9", "rsp returns to run", st(1), 0);
  endtask

  task automatic t_gate();
    offer(0, 32'h20, 1); switchedOut = 1; #1;
    chk("R2", "switched out", cacheReqValid, 0);
    switchedOut = 0; intPending = 1; privMode = 0; #1;
    chk("R2", "interrupt unpriv", cacheReqValid, 0);
    privMode = 1; #1;
    chk("R2", "interrupt priv passes", cacheReqValid, 1);
    tick(); idle();
    chk("R2", "priv fetch status", st(0), 2);
    respond(0);
  endtask

  task automatic t_refuse_retry();
    offer(2, 32'hB00, 0); #1;
    chk("R4", "reqValid", cacheReqValid, 1);
    tick(); idle();
    chk("R4", "status wait retry", st(2), 1);
    chk("R4", "blocked", cacheBlocked, 1);
    offer(3, 32'hC00, 1); #1;
    chk("R2", "blocked gate", cacheReqValid, 0);
    idle(); cacheRetry = 1; cacheReqAccept = 0; #1;
    chk("R6", "resend valid", cacheReqValid, 1);
    chk("R6", "resend addr", cacheReqAddr, 32'hB00);
    tick(); idle();
    chk("R6", "still blocked", cacheBlocked, 1);
    chk("R6", "still wait retry", st(2), 1);
    chk("R6", "no error", retryError, 0);
    cacheRetry = 1; cacheReqAccept = 1; #1;
    chk("R5", "resend tid", cacheReqTid, 2);
    chk("R5", "resend addr", cacheReqAddr, 32'hB00);
    tick(); idle();
    chk("R5", "unblocked", cacheBlocked, 0);
    chk("R5", "status wait rsp", st(2), 2);
    respond(2);
  endtask

  task automatic t_owner_squash();
    offer(0, 32'hC0, 0); tick(); idle();
    chk("R4", "blocked t0", cacheBlocked, 1);
    squashValid = 1; squashTid = 0; tick(); idle();
    chk("R7", "status squashing", st(0), 3);
    chk("R7", "still blocked", cacheBlocked, 1);
    tick();
    chk("R10", "back to run", st(0), 0);
    cacheRetry = 1; cacheReqAccept = 1; #1;
    chk("R7", "no resend", cacheReqValid, 0);
    tick(); idle();
    chk("R7", "unblocked by retry", cacheBlocked, 0);
    chk("R7", "no error", retryError, 0);
    chk("R7", "status stays run", st(0), 0);
  endtask

  task automatic t_other_squash();
    offer(1, 32'hD0, 0); tick(); idle();
    squashValid = 1; squashTid = 3; tick(); idle();
    chk("R8", "other squashing", st(3), 3);
    chk("R8", "blocked kept", cacheBlocked, 1);
    chk("R8", "owner still wait retry", st(1), 1);
    cacheRetry = 1; cacheReqAccept = 1; #1;
    chk("R8", "slot kept tid", cacheReqTid, 1);
    chk("R8", "slot kept addr", cacheReqAddr, 32'hD0);
    tick(); idle();
    chk("R5", "unblocked", cacheBlocked, 0);
  endtask

  task automatic t_not_running();
    offer(1, 32'hE0, 1); #1;
    chk("R11", "waiting thread blocked", cacheReqValid, 0);
    offer(2, 32'hE4, 1); squashValid = 1; squashTid = 2; #1;
    chk("R11", "squashed same cycle", cacheReqValid, 0);
    tick(); idle();
    chk("R11", "squash status", st(2), 3);
    respond(1);
    chk("R9", "t1 back to run", st(1), 0);
  endtask

  task automatic t_stray_retry();
    cacheRetry = 1; tick(); idle();
    chk("R12", "error raised", retryError, 1);
    tick();
    chk("R12", "error one cycle", retryError, 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rstN = 1;
        #1 t_reset();
        t_accept();
        t_gate();
        t_refuse_retry();
        t_owner_squash();
        t_other_squash();
        t_not_running();
        t_stray_retry();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule